// File: doc/BRIEF.md
# Self-Timed Page Programming Engine

This block sits between the serial command front end and the storage array of a small serial non-volatile memory. When a page-write instruction opens, it records the start address. It then collects each received data byte into a page-sized staging buffer. Consecutive bytes go to consecutive offsets, and the offset wraps inside the page. Nothing reaches the array while bytes are arriving. The commit decision is taken when chip select returns high.

At that moment the engine starts a programming cycle only if all of the following hold:
- at least one byte arrived;
- chip select rose on a whole-byte boundary;
- the write-enable latch was set;
- the status block did not report the target page as protected.

Once started, the engine holds a busy flag for a fixed number of clock cycles. During that period it drains the staged bytes to the array in ascending offset order. It raises a one-cycle request to clear the write-enable latch in the last busy cycle. If the attempt is refused only because the page is protected, the clear request is raised anyway and no cycle starts. While busy, the engine ignores every new instruction, byte and chip-select edge. Status reads are served by a neighbouring block.

Top module: `page_prog_engine`

## Requirements
- R1: After reset, `busy`, `wel_clr` and `mem_we` are all 0.
- R2: The first data byte after `wr_open` goes to offset `wr_addr` modulo PAGE_BYTES. Each further byte goes to the next offset. On commit, every written offset is written to the array exactly once, in ascending offset order, at address {page, offset}, where page = `wr_addr` / PAGE_BYTES.
- R3: The offset wraps from PAGE_BYTES-1 to 0 inside the same page. When a location receives more than one byte, only the last one is committed.
- R4: A cycle starts only if `wel` is 1 in the cycle where `cs_rise` is 1. Otherwise there is no array write, no busy period and no `wel_clr` pulse.
- R5: No cycle starts, and `wel_clr` stays 0, if `bits_aligned` is 0 when `cs_rise` arrives, or if no data byte was received.
- R6: If `locked` is 1 when an otherwise valid `cs_rise` arrives, no cycle starts and no array write occurs. `wel_clr` is 1 for exactly that one cycle.
- R7: `busy` rises in the cycle after the accepted `cs_rise` and stays 1 for exactly WRITE_CYCLES cycles. `wel_clr` is 1 only in the last of them.
- R8: While `busy` is 1, `wr_open`, `din_vld` and `cs_rise` have no effect. No extra writes occur and no second busy period follows.
- R9: A data byte presented in the same cycle as `cs_rise` belongs to the write being closed and is committed.
- R10: `mem_we` is 1 only while `busy` is 1, at most PAGE_BYTES times per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_open | input | 1 | Strobe: page-write instruction and address received |
| wr_addr | input | ADDR_W | Start address of the write |
| din_vld | input | 1 | Strobe: one data byte received |
| din | input | 8 | Data byte |
| cs_rise | input | 1 | Strobe: chip select returned high |
| bits_aligned | input | 1 | 1 when the bit count so far is a whole number of bytes |
| wel | input | 1 | Current write-enable latch state |
| locked | input | 1 | Protection verdict for `tgt_page` |
| tgt_page | output | ADDR_W-log2(PAGE_BYTES) | Page the open write targets |
| busy | output | 1 | Write-in-progress flag |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The last data byte and the chip-select rise can land in the same cycle, so the buffer write and the commit decision coincide. The bench provokes this by raising `cs_rise` together with the final `din_vld`. It then judges the result through the scoreboard: the byte must appear among the array writes, and the busy period must still last exactly WRITE_CYCLES. A second collision, new instruction traffic arriving during the busy window, is judged by requiring no extra writes and no second busy period.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BUSY = 2'd2
  } pgm_state_e;

  typedef enum logic [1:0] {
    VD_DROP = 2'd0,
    VD_GO   = 2'd1,
    VD_DENY = 2'd2
  } verdict_e;

  // Offset step inside a page of 'span' entries.
  function automatic logic [15:0] wrap_inc(input logic [15:0] v, input int unsigned span);
    logic [15:0] top;
    top = 16'(span - 1);
    return (v == top) ? 16'd0 : v + 16'd1;
  endfunction

  // Decision taken when chip select rises during a fill.
  function automatic verdict_e close_verdict(input logic have_data,
                                             input logic aligned,
                                             input logic wel_set,
                                             input logic prot);
    if (!have_data || !aligned || !wel_set) return VD_DROP;
    if (prot) return VD_DENY;
    return VD_GO;
  endfunction

endpackage

// File: rtl/pgm_buffer.sv
module pgm_buffer #(
  parameter int PAGE_BYTES = 32,
  parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [OFS_W-1:0] ofs_in,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic [OFS_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             any_data
);
  import pgm_pkg::*;

  logic [OFS_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] slot_v;
  logic [7:0]            slot_d [PAGE_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (clr) ptr_q <= ofs_in;
    else if (wr)  ptr_q <= OFS_W'(wrap_inc(16'(ptr_q), PAGE_BYTES));
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr && !clr && (ptr_q == OFS_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_v[g] <= 1'b0;
      else if (clr) slot_v[g] <= 1'b0;
      else if (hit) slot_v[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) slot_d[g] <= wdata;
    end
  end

  assign rd_data  = slot_d[rd_idx];
  assign rd_valid = slot_v[rd_idx];
  assign any_data = |slot_v;

endmodule

// File: rtl/pgm_timer.sv
module pgm_timer #(
  parameter int WRITE_CYCLES = 500,
  parameter int TMR_W        = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [TMR_W-1:0] cnt,
  output logic             last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (run)  cnt <= last ? '0 : cnt + TMR_W'(1);
    else           cnt <= '0;
  end

  assign last = run && (cnt == TMR_W'(WRITE_CYCLES - 1));

endmodule

// File: rtl/pgm_ctrl.sv
module pgm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_open,
  input  logic din_vld,
  input  logic cs_rise,
  input  logic bits_aligned,
  input  logic wel,
  input  logic locked,
  input  logic buf_any,
  input  logic tmr_last,
  output logic buf_clr,
  output logic buf_wr,
  output logic run,
  output logic clr_req
);
  import pgm_pkg::*;

  pgm_state_e st_q, st_d;
  verdict_e   vd;

  // A byte in the closing cycle counts as received.
  assign vd = close_verdict(buf_any | din_vld, bits_aligned, wel, locked);

  always_comb begin
    st_d    = st_q;
    buf_clr = 1'b0;
    buf_wr  = 1'b0;
    clr_req = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (wr_open) begin
          buf_clr = 1'b1;
          st_d    = ST_FILL;
        end
      end
      ST_FILL: begin
        if (wr_open) begin
          buf_clr = 1'b1;
        end else begin
          buf_wr = din_vld;
          if (cs_rise) begin
            case (vd)
              VD_GO:   st_d = ST_BUSY;
              VD_DENY: begin
                clr_req = 1'b1;
                st_d    = ST_IDLE;
              end
              default: st_d = ST_IDLE;
            endcase
          end
        end
      end
      ST_BUSY: begin
        if (tmr_last) begin
          clr_req = 1'b1;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign run = (st_q == ST_BUSY);

endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine #(
  parameter int ADDR_W       = 12,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 500,
  localparam int OFS_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - OFS_W,
  localparam int TMR_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              din_vld,
  input  logic [7:0]        din,
  input  logic              cs_rise,
  input  logic              bits_aligned,
  input  logic              wel,
  input  logic              locked,
  output logic [PAGE_W-1:0] tgt_page,
  output logic              busy,
  output logic              wel_clr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  logic             buf_clr, buf_wr, buf_any, rd_valid;
  logic [7:0]       rd_data;
  logic [OFS_W-1:0] scan_idx;
  logic [TMR_W-1:0] tcnt;
  logic             tmr_last, run, clr_req;
  logic             scan_on;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= '0;
    else if (buf_clr) page_q <= wr_addr[ADDR_W-1:OFS_W];
  end

  pgm_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_open      (wr_open),
    .din_vld      (din_vld),
    .cs_rise      (cs_rise),
    .bits_aligned (bits_aligned),
    .wel          (wel),
    .locked       (locked),
    .buf_any      (buf_any),
    .tmr_last     (tmr_last),
    .buf_clr      (buf_clr),
    .buf_wr       (buf_wr),
    .run          (run),
    .clr_req      (clr_req)
  );

  pgm_buffer #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .ofs_in   (wr_addr[OFS_W-1:0]),
    .wr       (buf_wr),
    .wdata    (din),
    .rd_idx   (scan_idx),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .any_data (buf_any)
  );

  pgm_timer #(.WRITE_CYCLES(WRITE_CYCLES), .TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .cnt   (tcnt),
    .last  (tmr_last)
  );

  // The first PAGE_BYTES busy cycles walk the page in ascending order.
  assign scan_on   = run && (tcnt < TMR_W'(PAGE_BYTES));
  assign scan_idx  = tcnt[OFS_W-1:0];
  assign mem_we    = scan_on && rd_valid;
  assign mem_addr  = {page_q, scan_idx};
  assign mem_wdata = rd_data;

  assign tgt_page  = page_q;
  assign busy      = run;
  assign wel_clr   = clr_req;

endmodule

// File: rtl/page_prog_engine_chk.sv
module page_prog_engine_chk #(
  parameter int WRITE_CYCLES = 500
) (
  input logic clk,
  input logic rst_n,
  input logic cs_rise,
  input logic bits_aligned,
  input logic wel,
  input logic locked,
  input logic busy,
  input logic wel_clr,
  input logic mem_we
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r10_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  a_r7_clr_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wel_clr) |=> !busy);

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy)) |-> (run_len == WRITE_CYCLES));

  a_r4_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && $past(cs_rise)));

  a_r5_start_needs_align: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bits_aligned));

  a_r6_locked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && locked && !busy) |=> !busy);

endmodule

bind page_prog_engine page_prog_engine_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_rise      (cs_rise),
  .bits_aligned (bits_aligned),
  .wel          (wel),
  .locked       (locked),
  .busy         (busy),
  .wel_clr      (wel_clr),
  .mem_we       (mem_we)
);

// File: tb/tb_page_prog_engine.sv
module tb_page_prog_engine;
  localparam int AW = 12;
  localparam int PB = 32;
  localparam int WC = 48;
  localparam int PW = AW - $clog2(PB);

  logic clk, rst_n;
  logic wr_open, din_vld, cs_rise, bits_aligned, wel, locked;
  logic [AW-1:0] wr_addr;
  logic [7:0]    din;
  logic [PW-1:0] tgt_page;
  logic busy, wel_clr, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  page_prog_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_addr(wr_addr),
    .din_vld(din_vld), .din(din), .cs_rise(cs_rise), .bits_aligned(bits_aligned),
    .wel(wel), .locked(locked), .tgt_page(tgt_page), .busy(busy),
    .wel_clr(wel_clr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [AW+7:0] exp_q [$];
  int busy_seen, clr_seen, we_seen;
  logic [7:0] pay [64];

  // Monitor: scoreboard pop on every array write.
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy)    busy_seen++;
      if (wel_clr) clr_seen++;
      if (mem_we) begin
        we_seen++;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R2: unexpected write actual=%h/%h expected none", mem_addr, mem_wdata);
        end else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          if ({mem_addr, mem_wdata} !== e) begin
            bad++;
            $display("FAIL R2/R3: write actual=%h/%h expected=%h/%h",
                     mem_addr, mem_wdata, e[AW+7:8], e[7:0]);
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 64; i++) pay[i] = 8'((i * 7 + seed * 13 + 3) & 255);
  endtask

  task automatic run_write(input logic [AW-1:0] a, input int n,
                           input bit wel_v, input bit locked_v, input bit aligned_v,
                           input bit same_end, input bit inject, input string req);
    logic [7:0] img [PB];
    bit         msk [PB];
    int         o, nwr;
    bit         go, deny;
    for (int k = 0; k < PB; k++) begin msk[k] = 0; img[k] = 8'h00; end
    o = int'(a) % PB;
    for (int i = 0; i < n; i++) begin
      img[o] = pay[i];
      msk[o] = 1;
      o = (o + 1) % PB;
    end
    go   = (n > 0) && aligned_v && wel_v && !locked_v;
    deny = (n > 0) && aligned_v && wel_v && locked_v;
    nwr  = 0;
    if (go) begin
      for (int k = 0; k < PB; k++) begin
        if (msk[k]) begin
          exp_q.push_back({AW'((int'(a) / PB) * PB + k), img[k]});
          nwr++;
        end
      end
    end
    busy_seen = 0; clr_seen = 0; we_seen = 0;
    wel = wel_v; locked = locked_v; bits_aligned = aligned_v;
    wr_open = 1'b1; wr_addr = a;
    step();
    wr_open = 1'b0;
    for (int i = 0; i < n; i++) begin
      din_vld = 1'b1;
      din     = pay[i];
      if (i == n - 1 && same_end) cs_rise = 1'b1;
      step();
    end
    din_vld = 1'b0;
    if (!same_end || n == 0) begin
      cs_rise = 1'b1;
      step();
    end
    cs_rise = 1'b0;
    // R7: busy is already up in the cycle following the accepted close
    check({req, " R7 busy start"}, int'(busy), int'(go));
    if (inject) begin
      // R8: traffic while busy must be ignored
      bits_aligned = 1'b1; wel = 1'b1; locked = 1'b0;
      step(); step();
      wr_open = 1'b1; wr_addr = a ^ AW'(12'h040);
      step();
      wr_open = 1'b0; din_vld = 1'b1; din = 8'hEE;
      step();
      din_vld = 1'b0; cs_rise = 1'b1;
      step();
      cs_rise = 1'b0;
    end
    repeat (WC + 12) step();
    check({req, " R7 busy cycles"}, busy_seen, go ? WC : 0);
    check({req, " R6/R7 wel_clr pulses"}, clr_seen, (go || deny) ? 1 : 0);
    check({req, " R10 write count"}, we_seen, nwr);
    check({req, " R2 pending writes"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; wr_open = 0; din_vld = 0; cs_rise = 0; bits_aligned = 1;
    wel = 0; locked = 0; wr_addr = '0; din = '0;
    repeat (3) step();
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 wel_clr", int'(wel_clr), 0);
    check("R1 mem_we", int'(mem_we), 0);
    rst_n = 1'b1;
    step();
    check("R1 busy after release", int'(busy), 0);

    fill(1); run_write(12'h105, 1,  1, 0, 1, 0, 0, "R2 single");
    fill(2); run_write(12'h7C4, 10, 1, 0, 1, 0, 0, "R2 mid page");
    fill(3); run_write(12'hFE0, 32, 1, 0, 1, 0, 0, "R10 full page");
    fill(4); run_write(12'h21E, 35, 1, 0, 1, 0, 0, "R3 wrap overwrite");
    fill(5); run_write(12'h300, 4,  0, 0, 1, 0, 0, "R4 no wel");
    fill(6); run_write(12'h340, 4,  1, 0, 0, 0, 0, "R5 unaligned");
    fill(7); run_write(12'h360, 0,  1, 0, 1, 0, 0, "R5 no data");
    fill(8); run_write(12'hC08, 3,  1, 1, 1, 0, 0, "R6 locked");
    fill(9); run_write(12'h4A2, 5,  1, 0, 1, 1, 0, "R9 same cycle");
    fill(10); run_write(12'h5E7, 6, 1, 0, 1, 0, 1, "R8 ignore busy");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule